// File: doc/BRIEF.md
# Event-Driven Acquisition Power Sequencer

This block switches power for a three-stage acquisition chain: a front-end board, a short-term storage board and a bulk-storage board that carries two drives. All stages are off by default. A target detection from an always-on watch circuit brings up the front-end first. The storage board comes up only after the front-end reports that it has initialised. The bulk stage uses the most power, so it is raised only to drain short-term storage. That happens when the storage board has signalled that it is nearly full, or when a host asks to retrieve data. During a transfer only the selected drive is powered.

Every power-up step waits a fixed settle interval, set in clock cycles by a parameter, before the next stage may follow. Power-down runs in reverse order and waits the same interval between stages. A host request that arrives while an acquisition is running is held and served once the acquisition ends. After the bulk transfer completes, the bulk stage and then the storage stage are turned off, and the sequencer rests with everything off.

Top module: `acq_power_seq`

## Requirements
- R1: After reset, and at any time reset is asserted, all enables (front, storage, bulk, both drives) are low. With no request the block stays all-off.
- R2: A high `watch_trig` sampled while idle turns on `en_front` on the next clock. `en_store` turns on the clock after `fe_ready` is sampled high, but `fe_ready` is looked at only after the front-end settle interval.
- R3: Each power-up step holds its stage on for exactly SETTLE_CYC clocks before the next step can be taken. A `fe_ready` that arrives earlier has no effect until then.
- R4: A low `watch_trig` during acquisition first turns off `en_front` while storage stays on. If no transfer is pending, `en_store` turns off SETTLE_CYC clocks later, and after a further SETTLE_CYC clocks the block is idle again. A trigger seen during that last interval is ignored until idle.
- R5: A `store_full` pulse seen at any time marks a transfer as pending. At the end of the acquisition, once the front-end settle-down interval has passed, `en_bulk` turns on while storage stays on.
- R6: After the bulk settle interval the transfer phase powers exactly one drive. `en_drive` is 2'b01 when `drive_sel`=0 and 2'b10 when `drive_sel`=1; it follows `drive_sel` and is 2'b00 outside the transfer phase.
- R7: `xfer_done` sampled during the transfer turns off both drives and `en_bulk` on the next clock. Storage turns off SETTLE_CYC clocks later, and the block is idle another SETTLE_CYC clocks after that.
- R8: A `host_req` while idle turns on `en_store` alone on the next clock, with the front-end never powered. The bulk stage and transfer then follow, each after its settle interval.
- R9: A `host_req` during an acquisition is held without disturbing it. After the acquisition ends, a transfer follows even if `store_full` was never raised, and it is served only once.
- R10: When `host_req` and `watch_trig` are both high while idle, retrieval takes precedence.
- R11: `en_front` and `en_bulk` are never high together, and `en_bulk` is high only while `en_store` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| watch_trig | input | 1 | Target detected by the watch circuit; level held for the acquisition |
| fe_ready | input | 1 | Front-end finished initialising |
| store_full | input | 1 | Short-term storage reached its threshold |
| host_req | input | 1 | Host asks for data retrieval |
| xfer_done | input | 1 | Bulk transfer complete |
| drive_sel | input | 1 | Active drive: 0 selects drive 0, 1 selects drive 1 |
| en_front | output | 1 | Front-end board power enable |
| en_store | output | 1 | Storage board power enable |
| en_bulk | output | 1 | Bulk-storage board power enable |
| en_drive | output | 2 | Per-drive power enables, bit i for drive i |

## Verification
Two events can land on the same edge. One case is a host request together with a watch trigger while idle; the vector table raises both in one cycle and expects storage alone to come up, with the front-end dark. The other case is a host request that arrives on the very edge where acquisition storage is being raised. That request must be held, leave the acquisition untouched, and produce exactly one transfer afterwards. This is judged by the enables during the acquisition, during power-down, and over an extra idle stretch afterwards.

// File: rtl/acq_power_pkg.sv
package acq_power_pkg;
  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_FE_UP   = 4'd1,
    S_FE_INIT = 4'd2,
    S_ST_UP   = 4'd3,
    S_ACQ     = 4'd4,
    S_FE_DN   = 4'd5,
    S_SR_UP   = 4'd6,
    S_BK_UP   = 4'd7,
    S_XFER    = 4'd8,
    S_BK_DN   = 4'd9,
    S_ST_DN   = 4'd10
  } seq_state_e;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == CW'(SETTLE_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SETTLE_CYC)); // R3
endmodule

// File: rtl/pend_flag.sv
module pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (clr)      q_d = 1'b0;
    else if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q); // R9
endmodule

// File: rtl/stage_enable_decode.sv
module stage_enable_decode
  import acq_power_pkg::*;
(
  input  seq_state_e state,
  input  logic       drive_sel,
  output logic       en_front,
  output logic       en_store,
  output logic       en_bulk,
  output logic [1:0] en_drive,
  output logic       settling
);
  always_comb begin
    en_front = 1'b0;
    en_store = 1'b0;
    en_bulk  = 1'b0;
    en_drive = 2'b00;
    settling = 1'b0;
    unique case (state)
      S_FE_UP:   begin en_front = 1'b1; settling = 1'b1; end
      S_FE_INIT: en_front = 1'b1;
      S_ST_UP:   begin en_front = 1'b1; en_store = 1'b1; settling = 1'b1; end
      S_ACQ:     begin en_front = 1'b1; en_store = 1'b1; end
      S_FE_DN,
      S_SR_UP,
      S_BK_DN:   begin en_store = 1'b1; settling = 1'b1; end
      S_BK_UP:   begin en_store = 1'b1; en_bulk = 1'b1; settling = 1'b1; end
      S_XFER: begin
        en_store = 1'b1;
        en_bulk  = 1'b1;
        en_drive = drive_sel ? 2'b10 : 2'b01;
      end
      S_ST_DN:   settling = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/acq_power_seq.sv
module acq_power_seq
  import acq_power_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       watch_trig,
  input  logic       fe_ready,
  input  logic       store_full,
  input  logic       host_req,
  input  logic       xfer_done,
  input  logic       drive_sel,
  output logic       en_front,
  output logic       en_store,
  output logic       en_bulk,
  output logic [1:0] en_drive
);
  seq_state_e state_q, state_d;
  logic settling, settled;
  logic host_q, thr_q, host_pend, thr_pend, in_xfer;

  assign in_xfer   = (state_q == S_XFER);
  assign host_pend = host_q | host_req;
  assign thr_pend  = thr_q | store_full;

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(settling), .done(settled)
  );

  pend_flag u_host_flag (
    .clk(clk), .rst_n(rst_n), .set(host_req), .clr(in_xfer), .q(host_q)
  );

  pend_flag u_thr_flag (
    .clk(clk), .rst_n(rst_n), .set(store_full), .clr(in_xfer), .q(thr_q)
  );

  stage_enable_decode u_dec (
    .state(state_q), .drive_sel(drive_sel),
    .en_front(en_front), .en_store(en_store), .en_bulk(en_bulk),
    .en_drive(en_drive), .settling(settling)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (host_pend)       state_d = S_SR_UP;
        else if (watch_trig) state_d = S_FE_UP;
      end
      S_FE_UP:   if (settled)    state_d = S_FE_INIT;
      S_FE_INIT: if (fe_ready)   state_d = S_ST_UP;
      S_ST_UP:   if (settled)    state_d = S_ACQ;
      S_ACQ:     if (!watch_trig) state_d = S_FE_DN;
      S_FE_DN:   if (settled)    state_d = (thr_pend || host_pend) ? S_BK_UP : S_ST_DN;
      S_SR_UP:   if (settled)    state_d = S_BK_UP;
      S_BK_UP:   if (settled)    state_d = S_XFER;
      S_XFER:    if (xfer_done)  state_d = S_BK_DN;
      S_BK_DN:   if (settled)    state_d = S_ST_DN;
      S_ST_DN:   if (settled)    state_d = S_IDLE;
      default:                   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  AST_FRONT_BULK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_front && en_bulk)); // R11
  AST_BULK_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    en_bulk |-> en_store); // R11
  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(en_drive) <= 1) && (!(|en_drive) || en_bulk)); // R6
  AST_BULK_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_bulk) |-> $past(en_store)); // R3
  AST_STORE_AFTER_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_store) && en_front) |-> $past(en_front)); // R2
  AST_STORE_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_store) |-> (!en_front && !en_bulk)); // R4
  AST_DONE_DROPS_BULK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && xfer_done) |=> (!en_bulk && en_drive == 2'b00)); // R7
endmodule

// File: tb/acq_power_seq_test.sv
module acq_power_seq_test;
  localparam int unsigned SETTLE = 3;
  localparam int NV = 38;

  logic clk, rst_n;
  logic watch_trig, fe_ready, store_full, host_req, xfer_done, drive_sel;
  logic en_front, en_store, en_bulk;
  logic [1:0] en_drive;

  int checks, fails;
  bit finished;

  acq_power_seq #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .watch_trig(watch_trig), .fe_ready(fe_ready),
    .store_full(store_full), .host_req(host_req), .xfer_done(xfer_done),
    .drive_sel(drive_sel), .en_front(en_front), .en_store(en_store),
    .en_bulk(en_bulk), .en_drive(en_drive)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {cycles, trig rdy full host done sel, front store bulk drv1 drv0, req}
  localparam logic [19:0] VEC [0:NV-1] = '{
    {4'd2, 6'b000000, 5'b00000, 5'd1},  // R1 idle
    {4'd1, 6'b100000, 5'b10000, 5'd2},  // R2 front up
    {4'd2, 6'b100000, 5'b10000, 5'd3},  // R3 settling
    {4'd1, 6'b110000, 5'b10000, 5'd3},  // R3 early ready no effect
    {4'd1, 6'b110000, 5'b11000, 5'd2},  // R2 storage up
    {4'd3, 6'b110000, 5'b11000, 5'd2},  // R2 acquiring
    {4'd1, 6'b000000, 5'b01000, 5'd4},  // R4 front off first
    {4'd2, 6'b000000, 5'b01000, 5'd4},  // R4 storage held
    {4'd1, 6'b000000, 5'b00000, 5'd4},  // R4 storage off
    {4'd1, 6'b100000, 5'b00000, 5'd4},  // R4 trig ignored
    {4'd1, 6'b100000, 5'b00000, 5'd4},  // R4
    {4'd1, 6'b100000, 5'b00000, 5'd4},  // R4 back to idle
    {4'd1, 6'b100000, 5'b10000, 5'd4},  // R4 re-armed
    {4'd3, 6'b100000, 5'b10000, 5'd3},  // R3
    {4'd1, 6'b110000, 5'b11000, 5'd2},  // R2
    {4'd3, 6'b111000, 5'b11000, 5'd5},  // R5 threshold seen
    {4'd1, 6'b000000, 5'b01000, 5'd5},  // R5 front off
    {4'd3, 6'b000000, 5'b01100, 5'd5},  // R5 bulk up
    {4'd3, 6'b000001, 5'b01110, 5'd6},  // R6 drive 1
    {4'd1, 6'b000000, 5'b01101, 5'd6},  // R6 drive 0
    {4'd1, 6'b000010, 5'b01000, 5'd7},  // R7 bulk off
    {4'd3, 6'b000000, 5'b00000, 5'd7},  // R7 storage off
    {4'd3, 6'b000000, 5'b00000, 5'd7},  // R7 idle
    {4'd1, 6'b100100, 5'b01000, 5'd10}, // R10 host wins
    {4'd3, 6'b000000, 5'b01100, 5'd8},  // R8 bulk up
    {4'd3, 6'b000000, 5'b01101, 5'd8},  // R8 transfer
    {4'd1, 6'b000010, 5'b01000, 5'd8},  // R8
    {4'd6, 6'b000000, 5'b00000, 5'd8},  // R8 idle
    {4'd1, 6'b100000, 5'b10000, 5'd9},  // R9 front up
    {4'd3, 6'b100000, 5'b10000, 5'd9},  // R9
    {4'd1, 6'b110100, 5'b11000, 5'd9},  // R9 host on same edge
    {4'd3, 6'b110000, 5'b11000, 5'd9},  // R9 acquisition undisturbed
    {4'd1, 6'b000000, 5'b01000, 5'd9},  // R9
    {4'd3, 6'b000000, 5'b01100, 5'd9},  // R9 bulk without threshold
    {4'd3, 6'b000001, 5'b01110, 5'd9},  // R9 transfer
    {4'd1, 6'b000011, 5'b01000, 5'd7},  // R7
    {4'd6, 6'b000000, 5'b00000, 5'd7},  // R7
    {4'd4, 6'b000000, 5'b00000, 5'd9}   // R9 served once
  };

  task automatic check(input logic [4:0] exp, input string req);
    logic [4:0] act;
    act = {en_front, en_store, en_bulk, en_drive};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: enables=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R11 monitor, counted as one check at the end
  int mon_bad;
  always @(negedge clk) if (rst_n && ((en_front && en_bulk) || (en_bulk && !en_store))) begin
    mon_bad++;
    $display("FAIL R11: front=%b store=%b bulk=%b expected exclusive", en_front, en_store, en_bulk);
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; mon_bad = 0; finished = 1'b0;
    rst_n = 1'b0;
    {watch_trig, fe_ready, store_full, host_req, xfer_done, drive_sel} = '0;
    repeat (2) @(negedge clk);
    check(5'b00000, "R1 in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {watch_trig, fe_ready, store_full, host_req, xfer_done, drive_sel} = VEC[i][15:10];
      repeat (int'(VEC[i][19:16])) @(negedge clk);
      check(VEC[i][9:5], $sformatf("R%0d vec%0d", VEC[i][4:0], i));
    end

    // R1 directed: asynchronous reset in the middle of an acquisition
    {watch_trig, fe_ready, store_full, host_req, xfer_done, drive_sel} = 6'b110000;
    repeat (5) @(negedge clk);
    check(5'b11000, "R2 before reset");
    #3 rst_n = 1'b0;
    #1 check(5'b00000, "R1 async reset");
    @(negedge clk);
    {watch_trig, fe_ready, store_full, host_req, xfer_done, drive_sel} = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(5'b00000, "R1 stays off");

    checks++;
    if (mon_bad != 0) fails++;
    finish_run();
  end
endmodule